// File: doc/BRIEF.md
# Ring-Chained FIFO Slices

This block builds one deep first-in first-out store out of several identical slices joined in a ring. Each slice owns a small memory and two ownership tokens. The write token marks the slice that takes the next incoming word. The read token marks the slice that supplies the next outgoing word. When a slice fills its last location it hands the write token to the next slice in the ring. When it empties its last location it hands the read token on in the same way. Because both tokens travel the same path, words leave in the order they arrived, even though they are spread across slices.

Each slice has three chain pins: a first-load input, an expansion input and an expansion output. The expansion output carries a one-cycle hand-off pulse that is tagged as a write hand-off or a read hand-off. The next slice's expansion input receives it. The top module wires the ring, ties the first-load input of slice 0 so that this slice holds both tokens after reset, and exposes the expansion lines for observation.

When the block is built with one slice, the expansion input is grounded and the slice runs on its own. Its pointers wrap in place and it keeps both tokens. Its write expansion line then reports half-full, and a retransmit pulse rewinds the read side. In a chain of two or more slices, retransmit has no effect. Reads are show-ahead: `rd_data` presents the oldest word whenever the store is not empty, and `rd_en` removes that word at the clock edge.

Top module: `fifo_chain`

## Requirements
- R1: Once reset is released, slice 0 holds both tokens, `empty` is 1, `full` is 0 and all expansion lines are 0.
- R2: A write is stored only when `full` is 0. `full` rises once NSLICE*DEPTH words are held, and a write presented while `full` is 1 stores nothing.
- R3: Words are read back in the order they were written, across slice boundaries. `rd_data` shows the oldest held word while `empty` is 0, and `rd_en` removes it at the clock edge.
- R4: In a chain, global write number n (counted from reset, starting at 0) goes to slice (n/DEPTH) mod NSLICE at location n mod DEPTH. While the write to location DEPTH-1 is being accepted, `link_wr` is one-hot at that slice's bit for that cycle only, and the next slice in the ring takes the write token.
- R5: In a chain, global read number n is taken from the same slice and location as write number n. While the read of location DEPTH-1 is being accepted, `link_rd` is one-hot at that slice's bit for that cycle only, and the next slice takes the read token.
- R6: `empty` is 1 while no words are held. A read presented while `empty` is 1 removes nothing and raises no `link_rd` bit.
- R7: In a chain, exactly one slice holds the write token and exactly one holds the read token in every cycle. After the last slice, both tokens wrap back to slice 0.
- R8: In a chain, a `retx` pulse given with `wr_en` and `rd_en` low changes neither the held words, nor the read order, nor the flags.
- R9: With NSLICE=1, the slice keeps both tokens and its pointers wrap in place. `link_rd[0]` stays 0, and `link_wr[0]` is 1 exactly while more than DEPTH/2 words are held.
- R10: With NSLICE=1, a `retx` pulse given with `wr_en` and `rd_en` low, after fewer than DEPTH writes since reset, moves reading back to the first location. The words written since reset can then be read again, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Word to write |
| rd_en | input | 1 | Read request (removes the word shown on rd_data) |
| retx | input | 1 | Retransmit pulse, acted on only when NSLICE=1 |
| rd_data | output | W | Oldest held word (show-ahead) |
| full | output | 1 | Write-token holder has no free location |
| empty | output | 1 | Read-token holder has no held word |
| link_wr | output | NSLICE | Per-slice write hand-off pulse; half-full flag when NSLICE=1 |
| link_rd | output | NSLICE | Per-slice read hand-off pulse |

## Verification
Every cycle, the embedded properties check three things. Exactly one write token and exactly one read token exist. A hand-off pulse never lasts longer than one cycle, and it always grants the token to the receiving slice. A slice's occupancy never goes past its depth. Properties also check that retransmit leaves a chained slice untouched and that a lone slice never loses its tokens. Some behaviour only the bench scenarios can show. These are the end-to-end word order across slice boundaries and ring wrap, and the exact slice and cycle of each hand-off pulse. They also include dropped writes when full and dropped reads when empty, the half-full threshold, and replay after a retransmit. The bench checks all of these against an arithmetic model of slice and location numbers.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  // Tagged hand-off carried on a slice's expansion output / input.
  typedef struct packed {
    logic wr;   // write-token hand-off (or half-full when running alone)
    logic rd;   // read-token hand-off
  } hop_t;
endpackage

// File: rtl/chain_ptr.sv
// One pointer plus its ownership token; used once for writes, once for reads.
module chain_ptr #(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          solo,
  input  logic          first_n,
  input  logic          step,
  input  logic          restart,
  input  logic          hop_in,
  output logic [AW-1:0] ptr,
  output logic          tok,
  output logic          hop_out
);
  logic          last;
  logic [AW-1:0] ptr_nx;
  logic          tok_nx;
  logic          ptr_en;

  assign last    = (ptr == AW'(DEPTH - 1));
  assign ptr_en  = step | restart;
  assign hop_out = step & last & ~solo;

  always_comb begin
    ptr_nx = ptr;
    if (restart)   ptr_nx = '0;
    else if (step) ptr_nx = last ? '0 : ptr + 1'b1;
  end

  always_comb begin
    tok_nx = tok;
    if (solo)               tok_nx = 1'b1;
    else if (step && last)  tok_nx = 1'b0;
    else if (hop_in)        tok_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      tok <= ~first_n;
    end else begin
      if (ptr_en) ptr <= ptr_nx;
      tok <= tok_nx;
    end
  end

  AST_HOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hop_out |=> !hop_out);                                            // R4
  AST_HOP_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!solo && hop_in && !(step && last)) |=> tok);                     // R7
  AST_SOLO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    solo |-> tok);                                                    // R9
endmodule

// File: rtl/chain_mem.sv
// Behavioural storage for one slice: one write port, combinational read.
module chain_mem #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/chain_slice.sv
module chain_slice
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         solo,
  input  logic         first_n,
  input  logic         retx,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  hop_t         hop_in,
  output hop_t         hop_out,
  output logic         wtok,
  output logic         rtok,
  output logic         hold_full,
  output logic         hold_empty,
  output logic [W-1:0] rd_word
);
  logic [CW-1:0] cnt, cnt_nx;
  logic          cnt_en;
  logic          lfull, lempty, half;
  logic          wr_acc, rd_acc, restart;
  logic [AW-1:0] wptr, rptr;
  logic          whop, rhop;
  logic [W-1:0]  mem_q;

  assign lfull   = (cnt == CW'(DEPTH));
  assign lempty  = (cnt == '0);
  assign half    = (cnt > CW'(DEPTH / 2));
  assign wr_acc  = wr_en & wtok & ~lfull;
  assign rd_acc  = rd_en & rtok & ~lempty;
  assign restart = solo & retx;
  assign cnt_en  = wr_acc | rd_acc | restart;

  always_comb begin
    if (restart) cnt_nx = CW'(wptr);
    else         cnt_nx = cnt + CW'(wr_acc) - CW'(rd_acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nx;
  end

  chain_ptr #(.DEPTH(DEPTH)) u_wside (
    .clk(clk), .rst_n(rst_n), .solo(solo), .first_n(first_n),
    .step(wr_acc), .restart(1'b0), .hop_in(hop_in.wr),
    .ptr(wptr), .tok(wtok), .hop_out(whop)
  );

  chain_ptr #(.DEPTH(DEPTH)) u_rside (
    .clk(clk), .rst_n(rst_n), .solo(solo), .first_n(first_n),
    .step(rd_acc), .restart(restart), .hop_in(hop_in.rd),
    .ptr(rptr), .tok(rtok), .hop_out(rhop)
  );

  chain_mem #(.DEPTH(DEPTH), .W(W)) u_mem (
    .clk(clk), .we(wr_acc), .wa(wptr), .wd(wr_data),
    .ra(rptr), .rd(mem_q)
  );

  // Alone, the write expansion line reports half-full instead of hand-offs.
  assign hop_out.wr = solo ? half : whop;
  assign hop_out.rd = solo ? 1'b0 : rhop;
  assign hold_full  = wtok & lfull;
  assign hold_empty = rtok & lempty;
  assign rd_word    = rtok ? mem_q : '0;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));                                               // R2
  AST_RETX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!solo && retx && !wr_en && !rd_en) |=> $stable(cnt));            // R8
  AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (lempty && !wr_acc && !restart) |=> lempty);                      // R6
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
  import fifo_chain_pkg::*;
#(
  parameter int NSLICE = 3,
  parameter int DEPTH  = 4,
  parameter int W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  input  logic              retx,
  output logic [W-1:0]      rd_data,
  output logic              full,
  output logic              empty,
  output logic [NSLICE-1:0] link_wr,
  output logic [NSLICE-1:0] link_rd
);
  localparam bit SOLO = (NSLICE == 1);

  logic              rs_q1, srst_n;
  hop_t              hop_o [NSLICE];
  logic [NSLICE-1:0] wtok_v, rtok_v, hf_v, he_v;
  logic [W-1:0]      word_v [NSLICE];

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rs_q1  <= 1'b1;
      srst_n <= rs_q1;
    end
  end

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    localparam int PREV = (i == 0) ? NSLICE - 1 : i - 1;
    hop_t hop_i;

    if (SOLO) begin : g_ground
      assign hop_i = '0;
    end else begin : g_ring
      assign hop_i = hop_o[PREV];
    end

    chain_slice #(.DEPTH(DEPTH), .W(W)) u_slice (
      .clk(clk), .rst_n(srst_n), .solo(SOLO), .first_n(i != 0),
      .retx(retx), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .hop_in(hop_i), .hop_out(hop_o[i]),
      .wtok(wtok_v[i]), .rtok(rtok_v[i]),
      .hold_full(hf_v[i]), .hold_empty(he_v[i]), .rd_word(word_v[i])
    );

    assign link_wr[i] = hop_o[i].wr;
    assign link_rd[i] = hop_o[i].rd;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NSLICE; k++) rd_data = rd_data | word_v[k];
  end

  assign full  = |hf_v;
  assign empty = |he_v;

  AST_ONE_WTOK: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(wtok_v) == 1);                                         // R7
  AST_ONE_RTOK: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(rtok_v) == 1);                                         // R7
  AST_HOP_ONEHOT: assert property (@(posedge clk) disable iff (!srst_n)
    !SOLO |-> ($onehot0(link_wr) && $onehot0(link_rd)));              // R5
endmodule

// File: tb/fifo_chain_tb.sv
module fifo_chain_tb;
  localparam int N  = 3;
  localparam int D  = 4;
  localparam int ND = N * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, retx = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic full, empty;
  logic [N-1:0] link_wr, link_rd;

  logic s_wr = 1'b0, s_rd = 1'b0, s_rt = 1'b0;
  logic [7:0] s_d = '0;
  logic [7:0] s_q;
  logic s_full, s_empty;
  logic [0:0] s_lw, s_lr;

  int nchk = 0, nfail = 0;
  int occ = 0, wi = 0, ri = 0;
  logic [7:0] mdl [ND];
  int socc = 0, swi = 0, sri = 0;
  logic [7:0] smdl [D];
  logic [15:0] lf = 16'hACE1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fifo_chain #(.NSLICE(N), .DEPTH(D), .W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .retx(retx), .rd_data(rd_data), .full(full),
    .empty(empty), .link_wr(link_wr), .link_rd(link_rd)
  );

  fifo_chain #(.NSLICE(1), .DEPTH(D), .W(8)) u_solo (
    .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .wr_data(s_d),
    .rd_en(s_rd), .retx(s_rt), .rd_data(s_q), .full(s_full),
    .empty(s_empty), .link_wr(s_lw), .link_rd(s_lr)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One chained cycle: drive, check pre-edge outputs, clock, update model.
  task automatic cyc(input logic w, input logic [7:0] d, input logic r, input logic x);
    bit wacc, racc;
    int elw, elr;
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; retx = x;
    #1;
    wacc = w && (occ < ND);
    racc = r && (occ > 0);
    elw = (wacc && (wi % D == D - 1)) ? (1 << ((wi / D) % N)) : 0;
    elr = (racc && (ri % D == D - 1)) ? (1 << ((ri / D) % N)) : 0;
    chk("R2 full", full, occ == ND);
    chk("R6 empty", empty, occ == 0);
    if (occ > 0) chk("R3 rd_data", rd_data, mdl[ri % ND]);
    chk("R4,R7 link_wr", link_wr, elw);
    chk("R5,R7 link_rd", link_rd, elr);
    @(posedge clk);
    if (wacc) begin mdl[wi % ND] = d; wi++; occ++; end
    if (racc) begin ri++; occ--; end
  endtask

  // One lone-slice cycle.
  task automatic scyc(input logic w, input logic [7:0] d, input logic r,
                      input logic x, input string tag);
    bit wacc, racc;
    @(negedge clk);
    s_wr = w; s_d = d; s_rd = r; s_rt = x;
    #1;
    wacc = w && (socc < D) && !x;
    racc = r && (socc > 0) && !x;
    chk("R9 half-full", s_lw, socc > D / 2);
    chk("R9 link_rd", s_lr, 0);
    chk("R9 full", s_full, socc == D);
    chk("R9 empty", s_empty, socc == 0);
    if (socc > 0) chk(tag, s_q, smdl[sri % D]);
    @(posedge clk);
    if (x) begin sri = 0; socc = swi; end
    if (wacc) begin smdl[swi % D] = d; swi++; socc++; end
    if (racc) begin sri++; socc--; end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: state right after reset.
    chk("R1 full", full, 0);
    chk("R1 empty", empty, 1);
    chk("R1 link_wr", link_wr, 0);
    chk("R1 link_rd", link_rd, 0);

    // Fill every location of every slice, then push one more (dropped).
    for (int k = 0; k < ND; k++) cyc(1'b1, 8'(k * 7 + 3), 1'b0, 1'b0);
    cyc(1'b1, 8'hEE, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    // Drain everything, then read once more while empty (ignored).
    for (int k = 0; k < ND; k++) cyc(1'b0, 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0);

    // Mixed traffic with alternating bias so full, empty and wraps recur.
    for (int k = 0; k < 480; k++) begin
      bit bias, w, r;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      bias = ((k / 40) % 2) == 0;
      w = bias ? (lf[0] | lf[1]) : (lf[0] & lf[1]);
      r = bias ? (lf[2] & lf[3]) : (lf[2] | lf[3]);
      cyc(w, lf[11:4], r, 1'b0);
    end
    while (occ > 0) cyc(1'b0, 8'h00, 1'b1, 1'b0);

    // R8: retransmit mid-stream in a chain changes nothing.
    for (int k = 0; k < 7; k++) cyc(1'b1, 8'(8'h40 + k), 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    @(negedge clk);
    retx = 1'b0;
    #1;
    chk("R8 rd_data after retx", rd_data, mdl[ri % ND]);
    chk("R8 empty after retx", empty, 0);
    while (occ > 0) cyc(1'b0, 8'h00, 1'b1, 1'b0);

    // Lone slice: half-full threshold and retransmit replay (R9, R10).
    for (int k = 0; k < 3; k++) scyc(1'b1, 8'(8'hA0 + k), 1'b0, 1'b0, "R9 data");
    scyc(1'b0, 8'h00, 1'b0, 1'b0, "R9 data");
    scyc(1'b0, 8'h00, 1'b1, 1'b0, "R9 data");
    scyc(1'b0, 8'h00, 1'b0, 1'b1, "R10 data");
    for (int k = 0; k < 3; k++) scyc(1'b0, 8'h00, 1'b1, 1'b0, "R10 replay");
    // Wrap the lone slice: fill past the end, overflow attempt, drain.
    for (int k = 0; k < D + 1; k++) scyc(1'b1, 8'(8'hC0 + k), 1'b0, 1'b0, "R9 data");
    for (int k = 0; k < D + 1; k++) scyc(1'b0, 8'h00, 1'b1, 1'b0, "R9 wrap data");
    scyc(1'b0, 8'h00, 1'b0, 1'b0, "R9 data");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule